// File: doc/BRIEF.md
# Reset Release Stretcher for a Destination Clock Domain

This block accepts an active-low reset request that may come from any clock domain and produces an active-low reset that belongs to a destination clock domain. The release of the produced reset is always aligned to the destination clock. It is held back by a fixed number of destination cycles, and only cycles whose enable input is high are counted. The way assertion is taken is set at build time. In immediate mode the output drops as soon as the request drops. In clock-aligned mode the output drops at the first enabled destination edge that sees the request low.

A down-counter sets the release delay. It is loaded whenever the request is recognised. After the request goes away it counts down once per enabled edge. The output is held asserted while the request is recognised or while the counter is above one. A status output shows whether the incoming request is currently recognised.

A typical use is to derive one reset per local clock domain from a global reset. Clock-aligned mode suits domains where an asynchronous reset path is not wanted. The enable input lets a gated domain pause the release sequence without losing its place.

Top module: `rst_hold_sync`

## Requirements
- R1: Both resets are active low, so a 0 on `rst_ni` or `rst_no` means reset. `in_rst_o` is high while the request is recognised, and `rst_no` is 0 whenever `in_rst_o` is 1.
- R2: In immediate mode (`MODE` = `ASSERT_ASYNC`), `rst_no` goes to 0 and `in_rst_o` goes to 1 as soon as `rst_ni` is 0, with no clock edge needed. A request pulse that ends between two edges still loads the hold counter.
- R3: In clock-aligned mode (`MODE` = `ASSERT_SYNC`), the request is recognised at the first destination edge with `en_i` high and `rst_ni` low. A pulse that ends before such an edge has no effect.
- R4: While the request is recognised, the hold counter stays at HOLD+1.
- R5: Once the request ends, `rst_no` stays 0 through exactly HOLD enabled edges. It returns to 1 just after the HOLD-th enabled edge.
- R6: An edge with `en_i` low neither recognises a request (clock-aligned mode) nor advances the countdown.
- R7: With HOLD = 0, `rst_no` is the inverse of `in_rst_o` with no added delay. The release happens in the same instant the request ends.
- R8: If the request returns during a countdown, the counter reloads and `rst_no` stays 0 without a pulse to 1.
- R9: The default HOLD is 2. The counter is ceil(log2(HOLD+2)) bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Destination clock |
| en_i | input | 1 | Edge enable; edges with this low are ignored |
| rst_ni | input | 1 | Incoming reset request, active low, any domain |
| rst_no | output | 1 | Generated reset, active low, destination domain |
| in_rst_o | output | 1 | High while the incoming request is recognised |

## Verification
The hardest case to reach is a request that begins and ends between two destination edges. In immediate mode this pulse must still start a full release sequence. In clock-aligned mode it must leave no trace. The bench drives a pulse a few nanoseconds after a rising edge and removes it before the next one. It then follows the stretched release on the immediate-mode instance while confirming that the clock-aligned instances stay idle. Gated edges placed in the middle of both recognition and countdown check that the counter's position is kept.

// File: rtl/rst_hold_pkg.sv
package rst_hold_pkg;

  typedef enum logic {
    ASSERT_ASYNC = 1'b0,
    ASSERT_SYNC  = 1'b1
  } assert_mode_e;

  // Width of the hold counter: it must hold HOLD+1.
  function automatic int cnt_width(input int hold);
    return (hold + 2 > 2) ? $clog2(hold + 2) : 1;
  endfunction

  // Value loaded while a request is recognised.
  function automatic int load_value(input int hold);
    return hold + 1;
  endfunction

endpackage

// File: rtl/rst_hold_capture.sv
module rst_hold_capture #(
  parameter rst_hold_pkg::assert_mode_e MODE = rst_hold_pkg::ASSERT_ASYNC
) (
  input  logic clk_i,
  input  logic en_i,
  input  logic rst_ni,
  output logic req_o
);

  generate
    if (MODE == rst_hold_pkg::ASSERT_ASYNC) begin : g_async
      // Request is seen the moment the input drops.
      assign req_o = ~rst_ni;
    end else begin : g_sync
      logic seen_q;
      always_ff @(posedge clk_i) begin
        if (en_i) seen_q <= ~rst_ni;
      end
      // Recognition starts at an enabled edge, ends as soon as input rises.
      assign req_o = seen_q & ~rst_ni;
    end
  endgenerate

endmodule

// File: rtl/rst_hold_counter.sv
module rst_hold_counter #(
  parameter rst_hold_pkg::assert_mode_e MODE = rst_hold_pkg::ASSERT_ASYNC,
  parameter int HOLD = 2,
  parameter int CW   = rst_hold_pkg::cnt_width(HOLD)
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          rst_ni,
  output logic [CW-1:0] cnt_o,
  output logic          busy_o
);

  localparam logic [CW-1:0] LOAD = CW'(rst_hold_pkg::load_value(HOLD));
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_dec;

  assign cnt_dec = (cnt_q != '0) ? cnt_q - ONE : '0;

  generate
    if (MODE == rst_hold_pkg::ASSERT_ASYNC) begin : g_async
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   cnt_q <= LOAD;
        else if (en_i) cnt_q <= cnt_dec;
      end
    end else begin : g_sync
      always_ff @(posedge clk_i) begin
        if (en_i) cnt_q <= (!rst_ni) ? LOAD : cnt_dec;
      end
    end
  endgenerate

  assign cnt_o  = cnt_q;
  assign busy_o = (cnt_q > ONE);

endmodule

// File: rtl/rst_hold_sync.sv
module rst_hold_sync #(
  parameter rst_hold_pkg::assert_mode_e MODE = rst_hold_pkg::ASSERT_ASYNC,
  parameter int HOLD = 2
) (
  input  logic clk_i,
  input  logic en_i,
  input  logic rst_ni,
  output logic rst_no,
  output logic in_rst_o
);

  localparam int CW = rst_hold_pkg::cnt_width(HOLD);

  logic          req;
  logic          hold_busy;
  logic [CW-1:0] hold_cnt;

  rst_hold_capture #(.MODE(MODE)) capture_i (
    .clk_i  (clk_i),
    .en_i   (en_i),
    .rst_ni (rst_ni),
    .req_o  (req)
  );

  rst_hold_counter #(.MODE(MODE), .HOLD(HOLD), .CW(CW)) counter_i (
    .clk_i  (clk_i),
    .en_i   (en_i),
    .rst_ni (rst_ni),
    .cnt_o  (hold_cnt),
    .busy_o (hold_busy)
  );

  assign in_rst_o = req;
  assign rst_no   = ~(req | hold_busy);

endmodule

// File: rtl/rst_hold_sync_chk.sv
module rst_hold_sync_chk #(
  parameter rst_hold_pkg::assert_mode_e MODE = rst_hold_pkg::ASSERT_ASYNC,
  parameter int HOLD = 2,
  parameter int CW   = rst_hold_pkg::cnt_width(HOLD)
) (
  input logic          clk_i,
  input logic          en_i,
  input logic          rst_ni,
  input logic          rst_no,
  input logic          in_rst_o,
  input logic [CW-1:0] hold_cnt
);

  localparam logic [CW-1:0] LOAD = CW'(rst_hold_pkg::load_value(HOLD));

  logic live_q = 1'b0;
  always_ff @(posedge clk_i) live_q <= 1'b1;

  a_r1_flag_forces_reset: assert property (@(negedge clk_i) disable iff (!live_q)
    in_rst_o |-> !rst_no);

  a_r4_hold_loaded: assert property (@(posedge clk_i) disable iff (!live_q)
    in_rst_o |=> (hold_cnt == LOAD));

  a_r5_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !in_rst_o && hold_cnt != '0) |=> (hold_cnt == $past(hold_cnt) - CW'(1)));

  a_r6_gate_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(rst_no));

  generate
    if (MODE == rst_hold_pkg::ASSERT_ASYNC) begin : g_async
      a_r2_assert_now: assert property (@(negedge clk_i) disable iff (!live_q)
        !rst_ni |-> (in_rst_o && !rst_no));
    end else begin : g_sync
      a_r3_seen_at_edge: assert property (@(posedge clk_i) disable iff (!live_q)
        (en_i && !rst_ni) |=> (in_rst_o || rst_ni));
    end
    if (HOLD > 0) begin : g_hold
      a_r5_release_on_enabled_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_no) |-> $past(en_i));
    end
  endgenerate

endmodule

bind rst_hold_sync rst_hold_sync_chk #(.MODE(MODE), .HOLD(HOLD)) chk_i (
  .clk_i    (clk_i),
  .en_i     (en_i),
  .rst_ni   (rst_ni),
  .rst_no   (rst_no),
  .in_rst_o (in_rst_o),
  .hold_cnt (hold_cnt)
);

// File: tb/rst_hold_sync_tb_top.sv
module rst_hold_sync_tb_top;

  logic clk = 1'b0;
  logic en  = 1'b1;
  logic rst_n = 1'b0;

  logic a_rst_n, a_in;
  logic s_rst_n, s_in;
  logic z_rst_n, z_in;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  // A: immediate mode, default hold (2)
  rst_hold_sync dut_i (
    .clk_i(clk), .en_i(en), .rst_ni(rst_n), .rst_no(a_rst_n), .in_rst_o(a_in));

  // S: clock-aligned mode, hold 3
  rst_hold_sync #(.MODE(rst_hold_pkg::ASSERT_SYNC), .HOLD(3)) dut_s_i (
    .clk_i(clk), .en_i(en), .rst_ni(rst_n), .rst_no(s_rst_n), .in_rst_o(s_in));

  // Z: clock-aligned mode, hold 0
  rst_hold_sync #(.MODE(rst_hold_pkg::ASSERT_SYNC), .HOLD(0)) dut_z_i (
    .clk_i(clk), .en_i(en), .rst_ni(rst_n), .rst_no(z_rst_n), .in_rst_o(z_in));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edge_then_sample();
    @(posedge clk);
    #1;
  endtask

  // {rst_n, en, exp A rst_no, exp S rst_no, exp S in_rst, exp Z rst_no}
  localparam int NV = 14;
  localparam logic [5:0] VEC [NV] = '{
    6'b110001, // release: A,S counting (R5)
    6'b111001, // A released after 2 enabled edges (R5,R9)
    6'b101001, // gated: nothing moves (R6)
    6'b101001, // gated again (R6)
    6'b111101, // S released after 3 enabled edges (R5)
    6'b000101, // A immediate, S waits for an enabled edge (R2,R3,R6)
    6'b010010, // S and Z recognise (R3)
    6'b110001, // Z releases at once (R7)
    6'b111001, // A out, S still counting
    6'b010010, // reassert mid-countdown (R8)
    6'b110001,
    6'b111001,
    6'b111101,
    6'b111101
  };

  initial begin
    // reset phase
    rst_n = 1'b0; en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset A rst_no", a_rst_n, 1'b0);
    chk("R1 reset A in_rst", a_in, 1'b1);
    chk("R1 reset S rst_no", s_rst_n, 1'b0);
    chk("R1 reset S in_rst", s_in, 1'b1);
    chk("R1 reset Z rst_no", z_rst_n, 1'b0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      rst_n = VEC[i][5];
      en    = VEC[i][4];
      edge_then_sample();
      chk($sformatf("R5/R6/R8 vec%0d A rst_no", i), a_rst_n, VEC[i][3]);
      chk($sformatf("R3/R5/R8 vec%0d S rst_no", i), s_rst_n, VEC[i][2]);
      chk($sformatf("R3 vec%0d S in_rst", i),       s_in,    VEC[i][1]);
      chk($sformatf("R7 vec%0d Z rst_no", i),       z_rst_n, VEC[i][0]);
    end

    // R2/R3: immediate versus clock-aligned assertion between edges
    @(negedge clk);
    rst_n = 1'b0; en = 1'b1;
    #1;
    chk("R2 A asserts without edge", a_rst_n, 1'b0);
    chk("R2 A flag without edge", a_in, 1'b1);
    chk("R3 S waits for edge", s_rst_n, 1'b1);
    chk("R3 S flag waits", s_in, 1'b0);
    edge_then_sample();
    chk("R3 S asserts at edge", s_rst_n, 1'b0);
    chk("R3 S flag at edge", s_in, 1'b1);
    chk("R7 Z asserts at edge", z_rst_n, 1'b0);

    // R7 instant release for hold 0; R5 stretch for others
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R7 Z releases instantly", z_rst_n, 1'b1);
    chk("R5 A held after release", a_rst_n, 1'b0);
    edge_then_sample();
    chk("R5 A after edge 1", a_rst_n, 1'b0);
    chk("R5 S after edge 1", s_rst_n, 1'b0);
    edge_then_sample();
    chk("R9 A after edge 2", a_rst_n, 1'b1);
    chk("R5 S after edge 2", s_rst_n, 1'b0);
    edge_then_sample();
    chk("R5 S after edge 3", s_rst_n, 1'b1);
    edge_then_sample();

    // R2/R3: short pulse between edges
    @(posedge clk);
    #2 rst_n = 1'b0;
    #3;
    chk("R2 A asserted by pulse", a_rst_n, 1'b0);
    rst_n = 1'b1;
    #1;
    chk("R2 A still held after pulse", a_rst_n, 1'b0);
    chk("R3 S ignores pulse", s_rst_n, 1'b1);
    chk("R3 Z ignores pulse", z_rst_n, 1'b1);
    edge_then_sample();
    chk("R3 S flag stays low", s_in, 1'b0);
    chk("R3 S stays released", s_rst_n, 1'b1);
    chk("R2 A pulse stretch edge 1", a_rst_n, 1'b0);
    edge_then_sample();
    chk("R2 A pulse stretch edge 2", a_rst_n, 1'b1);

    // R6: gated edges during recognition and countdown
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      edge_then_sample();
      chk("R6 S no recognition on gated edge", s_rst_n, 1'b1);
      chk("R6 A asserted", a_rst_n, 1'b0);
    end
    @(negedge clk);
    en = 1'b1;
    edge_then_sample();
    chk("R6 S recognises on enabled edge", s_rst_n, 1'b0);
    @(negedge clk);
    rst_n = 1'b1; en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      edge_then_sample();
      chk("R6 A no count on gated edge", a_rst_n, 1'b0);
      chk("R6 S no count on gated edge", s_rst_n, 1'b0);
    end
    @(negedge clk);
    en = 1'b1;
    edge_then_sample();
    chk("R6 A counts when enabled 1", a_rst_n, 1'b0);
    edge_then_sample();
    chk("R6 A counts when enabled 2", a_rst_n, 1'b1);
    chk("R6 S still counting", s_rst_n, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule